// File: doc/BRIEF.md
# Descriptor Command Ring Engine

This block consumes a power-of-two ring of fixed-size command descriptors that a host keeps in memory. Through a small register port the host sets the ring base address (two 32-bit halves), the log2 of the ring length and a producer index. While it is enabled, the engine fetches the two header words of each descriptor between its own consumer index and the producer index, one read at a time, through a simple request/valid memory read port. It then decodes the header and retires the entry.

Only the no-operation command is executed. Any other opcode is reported as an opcode fault, and the entry is still consumed. Events latch into sticky status bits that the host clears by writing ones to them. An enable mask selects which status bits drive the interrupt line. Clearing the enable bit lets the descriptor in flight finish, and the busy flag then drops so the host can tell that the engine has drained.

Top module: `ring_engine`

## Requirements
- R1: After reset every register reads zero, the interrupt output is low and no memory read is requested.
- R2: Register 0 bits 3:0 hold n and the ring has 2^n entries. The consumer index steps by one modulo 2^n, so it wraps to 0 after entry 2^n-1.
- R3: Register 1 holds the host producer index in bits 14:0 and returns the engine consumer index in bits 30:16. Writes do not change the consumer index, and bits 15 and 31 read zero.
- R4: The engine starts a descriptor only while enabled and while the consumer index differs from the producer index taken modulo 2^n.
- R5: Descriptor i sits at the 64-bit base ({register 2, register 3}) plus i times 128. Header word 0 is read at offset 0 and word 1 at offset 4. Each request holds its address until the cycle that has read-valid.
- R6: Word 1 bits 31:24 carry the opcode, and 0x00 is a no-operation that completes normally. Completion sets command-complete (status bit 14) only if bit 30 of word 0 is set.
- R7: Any opcode other than 0x00 sets opcode-error (status bit 13), and the consumer index still advances.
- R8: A read response flagged as an error sets command-read (status bit 12), abandons that descriptor and advances the consumer index.
- R9: While the engine is enabled and the base address bits 6:0 are not zero, queue-alignment (status bit 15) is set and no descriptor is fetched.
- R10: Register 5 bit 31 is a read/write enable and bit 30 is a read-only busy flag. After enable is cleared, the descriptor in flight finishes, busy falls, and no further descriptor starts.
- R11: Status bits in register 5 (15:5 and 0) are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R12: Register 4 is the interrupt enable, with writable bits only at the status positions (mask 0xFFE1). The interrupt output is the OR of status ANDed with that register.
- R13: A write to register address 6 or 7 sets illegal-access (status bit 0) and changes no other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory read request, held until read-valid |
| mem_addr | output | 64 | Byte address of the requested header word |
| mem_rvalid | input | 1 | Read response valid |
| mem_rerr | input | 1 | Read response carries an error |
| mem_rdata | input | 32 | Read response data |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
On every cycle, the assertions check four things: a pending request keeps its address until its response arrives; a fetch never begins at a misaligned descriptor address; the engine stays idle when the ring is empty or it is disabled; and the consumer index only ever moves by one step modulo the ring size. Some behaviours can only be shown through the bench's scenarios. These are the exact status bit left behind by each opcode or read error, the write-one-to-clear and interrupt-mask behaviour, the drain after disable, and the side-effect-free handling of undefined register addresses. The bench checks them against its behavioural model and against fixed expected register values.

// File: rtl/ring_pkg.sv
package ring_pkg;

    // register word select
    localparam logic [2:0] RA_SIZE    = 3'd0;
    localparam logic [2:0] RA_PTR     = 3'd1;
    localparam logic [2:0] RA_BASE_HI = 3'd2;
    localparam logic [2:0] RA_BASE_LO = 3'd3;
    localparam logic [2:0] RA_IEN     = 3'd4;
    localparam logic [2:0] RA_CSR     = 3'd5;

    localparam int CSR_EN_BIT   = 31;
    localparam int CSR_BUSY_BIT = 30;
    localparam int PTR_RD_LSB   = 16;

    // status positions, shared by the interrupt enable register
    localparam int ST_QALIGN  = 15;
    localparam int ST_DONE    = 14;
    localparam int ST_BADOP   = 13;
    localparam int ST_CMD_RD  = 12;
    localparam int ST_CMD_WR  = 11;
    localparam int ST_DAT_RD  = 10;
    localparam int ST_DAT_WR  = 9;
    localparam int ST_INT_LEN = 8;
    localparam int ST_EXT_LEN = 7;
    localparam int ST_BLK     = 6;
    localparam int ST_KEY     = 5;
    localparam int ST_ILLEGAL = 0;

    localparam logic [31:0] STAT_MASK =
        (32'd1 << ST_QALIGN)  | (32'd1 << ST_DONE)    | (32'd1 << ST_BADOP)  |
        (32'd1 << ST_CMD_RD)  | (32'd1 << ST_CMD_WR)  | (32'd1 << ST_DAT_RD) |
        (32'd1 << ST_DAT_WR)  | (32'd1 << ST_INT_LEN) | (32'd1 << ST_EXT_LEN) |
        (32'd1 << ST_BLK)     | (32'd1 << ST_KEY)     | (32'd1 << ST_ILLEGAL);

    localparam logic [7:0] OPC_NOP = 8'h00;
    localparam int WORD_BYTES = 4;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_WORD0,
        FS_WORD1,
        FS_EXEC
    } fetch_state_e;

    typedef struct packed {
        logic        ctx_blk;
        logic        want_irq;
        logic [17:0] ctx_idx;
        logic [7:0]  opcode;
        logic [3:0]  iter;
        logic [15:0] len_bytes;
    } hdr_t;

endpackage

// File: rtl/ring_decode.sv
module ring_decode
    import ring_pkg::*;
(
    input  logic [31:0] word0,
    input  logic [31:0] word1,
    output hdr_t        hdr,
    output logic        op_is_nop
);

    logic unused_hdr_gap;

    always_comb begin
        hdr.ctx_blk   = word0[31];
        hdr.want_irq  = word0[30];
        hdr.ctx_idx   = word0[17:0];
        hdr.opcode    = word1[31:24];
        hdr.iter      = word1[19:16];
        hdr.len_bytes = word1[15:0];
    end

    assign op_is_nop      = (hdr.opcode == OPC_NOP);
    assign unused_hdr_gap = ^{word0[29:18], word1[23:20]};

endmodule

// File: rtl/ring_regs.sv
module ring_regs
    import ring_pkg::*;
#(
    parameter int IDX_W  = 15,
    parameter int LEN_W  = 4,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic [31:0]       hw_set,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              busy,
    output logic [31:0]       reg_rdata,
    output logic              en,
    output logic [LEN_W-1:0]  log_len,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [ADDR_W-1:0] base,
    output logic              irq
);

    typedef struct packed {
        logic [LEN_W-1:0] log_len;
        logic [IDX_W-1:0] wr;
        logic [31:0]      base_hi;
        logic [31:0]      base_lo;
        logic [31:0]      ien;
        logic [31:0]      stat;
        logic             en;
    } regs_t;

    regs_t regs_q, regs_d;

    always_comb begin
        logic [31:0] set_v;
        logic [31:0] clr_v;
        regs_d = regs_q;
        set_v  = hw_set & STAT_MASK;
        clr_v  = '0;
        if (reg_we) begin
            case (reg_addr)
                RA_SIZE:    regs_d.log_len = reg_wdata[LEN_W-1:0];
                RA_PTR:     regs_d.wr      = reg_wdata[IDX_W-1:0];
                RA_BASE_HI: regs_d.base_hi = reg_wdata;
                RA_BASE_LO: regs_d.base_lo = reg_wdata;
                RA_IEN:     regs_d.ien     = reg_wdata & STAT_MASK;
                RA_CSR: begin
                    regs_d.en = reg_wdata[CSR_EN_BIT];
                    clr_v     = reg_wdata & STAT_MASK;
                end
                default:    set_v[ST_ILLEGAL] = 1'b1;
            endcase
        end
        // a hardware event in the same cycle wins over the clear
        regs_d.stat = (regs_q.stat & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_SIZE:    reg_rdata = 32'(regs_q.log_len);
            RA_PTR:     reg_rdata = (32'(rd_idx) << PTR_RD_LSB) | 32'(regs_q.wr);
            RA_BASE_HI: reg_rdata = regs_q.base_hi;
            RA_BASE_LO: reg_rdata = regs_q.base_lo;
            RA_IEN:     reg_rdata = regs_q.ien;
            RA_CSR: begin
                reg_rdata               = regs_q.stat;
                reg_rdata[CSR_EN_BIT]   = regs_q.en;
                reg_rdata[CSR_BUSY_BIT] = busy;
            end
            default:    reg_rdata = '0;
        endcase
    end

    assign en      = regs_q.en;
    assign log_len = regs_q.log_len;
    assign wr_idx  = regs_q.wr;
    assign base    = ADDR_W'({regs_q.base_hi, regs_q.base_lo});
    assign irq     = |(regs_q.stat & regs_q.ien);

endmodule

// File: rtl/ring_fetch.sv
module ring_fetch
    import ring_pkg::*;
#(
    parameter int IDX_W      = 15,
    parameter int LEN_W      = 4,
    parameter int ADDR_W     = 64,
    parameter int DESC_WORDS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [LEN_W-1:0]  log_len,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] base,
    input  logic              mem_rvalid,
    input  logic              mem_rerr,
    input  logic [31:0]       mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              busy,
    output logic [31:0]       hw_set
);

    localparam int DESC_LOG2 = $clog2(DESC_WORDS * WORD_BYTES);

    typedef struct packed {
        fetch_state_e     st;
        logic [IDX_W-1:0] rd;
        logic [31:0]      w0;
        logic [31:0]      w1;
    } fetch_t;

    fetch_t f_q, f_d;

    hdr_t hdr;
    logic op_is_nop;
    logic unused_hdr;

    ring_decode u_decode (
        .word0     (f_q.w0),
        .word1     (f_q.w1),
        .hdr       (hdr),
        .op_is_nop (op_is_nop)
    );

    assign unused_hdr = ^{hdr.ctx_blk, hdr.ctx_idx, hdr.opcode, hdr.iter, hdr.len_bytes};

    logic [IDX_W:0]     mask_wide;
    logic [IDX_W-1:0]   ring_mask;
    logic [IDX_W-1:0]   rd_step;
    logic               misaligned;
    logic               pending;
    logic [ADDR_W-1:0]  desc_addr;

    always_comb begin
        mask_wide  = ((IDX_W+1)'(1) << log_len) - (IDX_W+1)'(1);
        ring_mask  = mask_wide[IDX_W-1:0];
        rd_step    = (f_q.rd + IDX_W'(1)) & ring_mask;
        misaligned = |base[DESC_LOG2-1:0];
        pending    = (f_q.rd != (wr_idx & ring_mask));
        desc_addr  = base + (ADDR_W'(f_q.rd) << DESC_LOG2);
    end

    always_comb begin
        f_d    = f_q;
        hw_set = '0;
        if (en && misaligned) hw_set[ST_QALIGN] = 1'b1;
        case (f_q.st)
            FS_IDLE: begin
                if (en && !misaligned && pending) f_d.st = FS_WORD0;
            end
            FS_WORD0, FS_WORD1: begin
                if (mem_rvalid) begin
                    if (mem_rerr) begin
                        hw_set[ST_CMD_RD] = 1'b1;
                        f_d.rd = rd_step;
                        f_d.st = FS_IDLE;
                    end else if (f_q.st == FS_WORD0) begin
                        f_d.w0 = mem_rdata;
                        f_d.st = FS_WORD1;
                    end else begin
                        f_d.w1 = mem_rdata;
                        f_d.st = FS_EXEC;
                    end
                end
            end
            FS_EXEC: begin
                if (op_is_nop) begin
                    if (hdr.want_irq) hw_set[ST_DONE] = 1'b1;
                end else begin
                    hw_set[ST_BADOP] = 1'b1;
                end
                f_d.rd = rd_step;
                f_d.st = FS_IDLE;
            end
            default: f_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: FS_IDLE, rd: '0, w0: '0, w1: '0};
        else        f_q <= f_d;
    end

    assign mem_req  = (f_q.st == FS_WORD0) || (f_q.st == FS_WORD1);
    assign mem_addr = desc_addr + ((f_q.st == FS_WORD1) ? ADDR_W'(WORD_BYTES) : '0);
    assign rd_idx   = f_q.rd;
    assign busy     = (f_q.st != FS_IDLE);

endmodule

// File: rtl/ring_engine.sv
module ring_engine
    import ring_pkg::*;
#(
    parameter int IDX_W      = 15,
    parameter int LEN_W      = 4,
    parameter int ADDR_W     = 64,
    parameter int DESC_WORDS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic              mem_rerr,
    input  logic [31:0]       mem_rdata,
    output logic              irq
);

    logic              ctrl_en;
    logic              fetch_busy;
    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic [LEN_W-1:0]  log_len;
    logic [ADDR_W-1:0] ring_base;
    logic [31:0]       hw_set;

    ring_regs #(
        .IDX_W  (IDX_W),
        .LEN_W  (LEN_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .hw_set    (hw_set),
        .rd_idx    (rd_idx),
        .busy      (fetch_busy),
        .reg_rdata (reg_rdata),
        .en        (ctrl_en),
        .log_len   (log_len),
        .wr_idx    (wr_idx),
        .base      (ring_base),
        .irq       (irq)
    );

    ring_fetch #(
        .IDX_W      (IDX_W),
        .LEN_W      (LEN_W),
        .ADDR_W     (ADDR_W),
        .DESC_WORDS (DESC_WORDS)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (ctrl_en),
        .log_len    (log_len),
        .wr_idx     (wr_idx),
        .base       (ring_base),
        .mem_rvalid (mem_rvalid),
        .mem_rerr   (mem_rerr),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .rd_idx     (rd_idx),
        .busy       (fetch_busy),
        .hw_set     (hw_set)
    );

endmodule

// File: rtl/ring_engine_chk.sv
module ring_engine_chk #(
    parameter int IDX_W      = 15,
    parameter int LEN_W      = 4,
    parameter int ADDR_W     = 64,
    parameter int DESC_WORDS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              en,
    input logic              busy,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [LEN_W-1:0]  log_len
);

    localparam int DESC_LOG2 = $clog2(DESC_WORDS * 4);

    logic [IDX_W:0]   mask_wide;
    logic [IDX_W-1:0] mask;

    assign mask_wide = ((IDX_W+1)'(1) << log_len) - (IDX_W+1)'(1);
    assign mask      = mask_wide[IDX_W-1:0];

    // R5: an unanswered request keeps its address
    a_r5_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid && !reg_we |=> mem_req && $stable(mem_addr));

    // R9: a fetch never begins at a misaligned descriptor
    a_r9_aligned_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) && !$past(reg_we) |-> (mem_addr[DESC_LOG2-1:0] == '0));

    // R4: empty ring keeps the engine idle
    a_r4_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && (rd_idx == (wr_idx & mask)) |=> !mem_req);

    // R10: nothing starts while disabled
    a_r10_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !en |=> !mem_req);

    // R2: consumer index moves one step modulo the ring size
    a_r2_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_idx) |-> rd_idx == ((($past(rd_idx)) + IDX_W'(1)) & $past(mask)));

endmodule

bind ring_engine ring_engine_chk #(
    .IDX_W      (IDX_W),
    .LEN_W      (LEN_W),
    .ADDR_W     (ADDR_W),
    .DESC_WORDS (DESC_WORDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .en         (ctrl_en),
    .busy       (fetch_busy),
    .rd_idx     (rd_idx),
    .wr_idx     (wr_idx),
    .log_len    (log_len)
);

// File: tb/ring_engine_bench.sv
`timescale 1ns/1ps
module ring_engine_bench;

    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic        mem_rerr = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ring_engine u_ring_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rerr(mem_rerr),
        .mem_rdata(mem_rdata), .irq(irq)
    );

    // host memory
    bit [31:0] mem_words [longint unsigned];
    bit        mem_bad   [longint unsigned];
    int        resp_cnt = 0;

    always @(negedge clk) begin
        if (!rst_n || !mem_req) begin
            mem_rvalid = 1'b0; mem_rerr = 1'b0; resp_cnt = 0;
        end else if (resp_cnt == LAT) begin
            mem_rvalid = 1'b1;
            mem_rerr   = mem_bad.exists(mem_addr);
            mem_rdata  = mem_words.exists(mem_addr) ? mem_words[mem_addr] : 32'h0;
            resp_cnt   = 0;
        end else begin
            mem_rvalid = 1'b0; mem_rerr = 1'b0; resp_cnt++;
        end
    end

    // behavioural reference
    int unsigned m_len, m_wr, m_rd, m_phase;
    logic [31:0] m_hi, m_lo, m_ien, m_stat, m_w0, m_w1;
    logic        m_en;

    always @(posedge clk) begin
        logic [31:0] set_v, clr_v;
        int unsigned msk;
        if (!rst_n) begin
            m_len = 0; m_wr = 0; m_rd = 0; m_phase = 0;
            m_hi = 0; m_lo = 0; m_ien = 0; m_stat = 0; m_w0 = 0; m_w1 = 0; m_en = 0;
        end else begin
            msk = (1 << m_len) - 1;
            set_v = 0; clr_v = 0;
            if (m_en && m_lo[6:0] != 0) set_v[15] = 1'b1;
            case (m_phase)
                0: if (m_en && m_lo[6:0] == 0 && m_rd != (m_wr & msk)) m_phase = 1;
                1, 2: if (mem_rvalid) begin
                    if (mem_rerr) begin
                        set_v[12] = 1'b1; m_rd = (m_rd + 1) & msk; m_phase = 0;
                    end else begin
                        if (m_phase == 1) m_w0 = mem_rdata; else m_w1 = mem_rdata;
                        m_phase = m_phase + 1;
                    end
                end
                default: begin
                    if (m_w1[31:24] == 8'h00) begin
                        if (m_w0[30]) set_v[14] = 1'b1;
                    end else set_v[13] = 1'b1;
                    m_rd = (m_rd + 1) & msk; m_phase = 0;
                end
            endcase
            if (reg_we) begin
                case (reg_addr)
                    3'd0: m_len = reg_wdata[3:0];
                    3'd1: m_wr  = reg_wdata[14:0];
                    3'd2: m_hi  = reg_wdata;
                    3'd3: m_lo  = reg_wdata;
                    3'd4: m_ien = reg_wdata & 32'hFFE1;
                    3'd5: begin m_en = reg_wdata[31]; clr_v = reg_wdata & 32'hFFE1; end
                    default: set_v[0] = 1'b1;
                endcase
            end
            m_stat = (m_stat & ~clr_v) | set_v;
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_len;
            3'd1: return (m_rd << 16) | m_wr;
            3'd2: return m_hi;
            3'd3: return m_lo;
            3'd4: return m_ien;
            3'd5: return {m_en, (m_phase != 0), m_stat[29:0]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R5", "mem_req", 64'(mem_req), 64'(m_phase == 1 || m_phase == 2));
            if (m_phase == 1 || m_phase == 2)
                check("R5", "mem_addr", mem_addr,
                      {m_hi, m_lo} + 64'(m_rd) * 128 + ((m_phase == 2) ? 64'd4 : 64'd0));
            check("R12", "irq", 64'(irq), 64'(|(m_stat & m_ien)));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // read, compare with reference and with a fixed expectation
    task automatic rchk(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, $sformatf("reg%0d vs model", a), 64'(v), 64'(m_read(a)));
        check(req, $sformatf("reg%0d", a), 64'(v), 64'(exp));
    endtask

    task automatic wait_idle(input int target);
        logic [31:0] c, p;
        for (int i = 0; i < 400; i++) begin
            rd(3'd5, c);
            rd(3'd1, p);
            if (!c[30] && p[30:16] == 15'(target)) break;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    function automatic longint unsigned desc(input int i);
        return 64'h0000_0001_0000_1000 + 64'(i) * 128;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        mem_words[desc(0)]     = 32'h4000_0000; mem_words[desc(0) + 4] = 32'h0000_0000;
        mem_words[desc(1)]     = 32'h0000_0000; mem_words[desc(1) + 4] = 32'h0000_0010;
        mem_words[desc(2)]     = 32'h4000_0000; mem_words[desc(2) + 4] = 32'h0301_0040;
        mem_words[desc(3)]     = 32'h4000_0005; mem_words[desc(3) + 4] = 32'h0000_0000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 6; a++) rchk("R1", 3'(a), 32'h0);
        check("R1", "irq after reset", 64'(irq), 64'd0);

        wr(3'd0, 32'd2);
        wr(3'd2, 32'h1);
        wr(3'd3, 32'h1000);
        wr(3'd4, 32'hFFE1);
        wr(3'd5, 32'h8000_0000);
        repeat (10) @(negedge clk);
        rchk("R4", 3'd1, 32'h0);            // empty ring: nothing consumed
        rchk("R10", 3'd5, 32'h8000_0000);

        // R3/R6 two NOPs, first with completion interrupt
        wr(3'd1, 32'hFFFF_0002);
        wait_idle(2);
        rchk("R3", 3'd1, 32'h0002_0002);
        rchk("R6", 3'd5, 32'h8000_4000);
        check("R12", "irq with done", 64'(irq), 64'd1);

        // R11 write-one-to-clear
        wr(3'd5, 32'h8000_0000);
        rchk("R11", 3'd5, 32'h8000_4000);
        wr(3'd5, 32'h8000_4000);
        rchk("R11", 3'd5, 32'h8000_0000);
        check("R11", "irq after clear", 64'(irq), 64'd0);

        // R2 wrap, R7 bad opcode, R6 set-interrupt NOP
        wr(3'd1, 32'h0);
        wait_idle(0);
        rchk("R2", 3'd1, 32'h0000_0000);
        rchk("R7", 3'd5, 32'h8000_6000);

        // R12 masking
        wr(3'd4, 32'h0);
        check("R12", "irq masked", 64'(irq), 64'd0);
        wr(3'd4, 32'h0000_2000);
        check("R12", "irq opcode only", 64'(irq), 64'd1);
        wr(3'd4, 32'hFFFF_FFFF);
        rchk("R12", 3'd4, 32'h0000_FFE1);
        wr(3'd5, 32'h8000_FFE1);
        rchk("R11", 3'd5, 32'h8000_0000);

        // R8 read error on header word 1 of entry 0
        mem_bad[desc(0) + 4] = 1'b1;
        wr(3'd1, 32'h1);
        wait_idle(1);
        rchk("R8", 3'd5, 32'h8000_1000);
        rchk("R8", 3'd1, 32'h0001_0001);
        wr(3'd5, 32'h8000_FFE1);

        // R9 misaligned base
        wr(3'd3, 32'h1010);
        wr(3'd1, 32'h2);
        repeat (20) @(negedge clk);
        rchk("R9", 3'd1, 32'h0001_0002);
        rchk("R9", 3'd5, 32'h8000_8000);
        wr(3'd3, 32'h1000);
        wait_idle(2);
        wr(3'd5, 32'h8000_FFE1);
        rchk("R9", 3'd5, 32'h8000_0000);

        // R10 drain after disable
        wr(3'd1, 32'h0);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (mem_req) break;
        end
        wr(3'd5, 32'h0);
        wait_idle(3);
        rchk("R10", 3'd5, 32'h0000_2000);
        repeat (20) @(negedge clk);
        rchk("R10", 3'd1, 32'h0003_0000);

        // R13 undefined addresses
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'h8000_0003);
        rchk("R13", 3'd5, 32'h0000_2001);
        rchk("R13", 3'd0, 32'h2);
        rchk("R13", 3'd1, 32'h0003_0000);
        rchk("R13", 3'd2, 32'h1);
        rchk("R13", 3'd3, 32'h1000);
        rchk("R13", 3'd4, 32'hFFE1);

        // re-enable and finish the last entry
        wr(3'd5, 32'h8000_FFE1);
        wait_idle(0);
        rchk("R6", 3'd5, 32'h8000_4000);

        // R2 single-entry ring never has work
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h5);
        repeat (15) @(negedge clk);
        rchk("R2", 3'd1, 32'h0000_0005);
        rchk("R2", 3'd5, 32'h8000_4000);

        finish_run();
    end

endmodule